// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a device DMA address into a system page address. Each request carries the address and the context of the issuing function: the table origin word, the inclusive address window, the function state and a translation-enable flag. The block first screens the request. A function that may not translate is refused. The hardwired interrupt-message address is passed straight through to the interrupt target. An address outside the window is refused. Only a request that survives all three screens starts a table walk.

The walk reads three 64-bit entries from memory, one level at a time: a region entry, then a segment entry, then a page entry. It uses a request/acknowledge read port whose latency may vary. An upper-level entry must carry the type code of its own level and a non-zero next-table base, or the walk stops early with no permission. One request is handled at a time. The result comes back as a single-cycle response pulse.

Top module: `dma_xlate_walker`

## Requirements
- R1: Translation is attempted only when `req_fstate` is 3 (enabled) or 4 (blocked) and `req_xlat_en` is 1. The other states are 0 reserved, 1 standby and 2 disabled. If the check fails, the response has `rsp_rw`=0, `rsp_msi`=0 and `rsp_addr`=0, and no memory read is issued. This check is made before every other check.
- R2: A permitted request whose address equals the interrupt-message address (default 0x00000000FE000000) gets a response with `rsp_msi`=1, `rsp_rw`=1 and `rsp_addr` equal to the request address. The window is not checked for this request, and no read is issued.
- R3: A permitted, non-interrupt request with an address below `req_base` or above `req_limit` gets a response with `rsp_rw`=0 and `rsp_addr`=0, and no read is issued. Both bounds are inclusive.
- R4: The table origin is `req_origin` with bits [3:0] cleared. The first read goes to origin + 8 × region index, where the region index is address bits [52:42]. Address bits above 52 are ignored.
- R5: Reads follow the fixed order region, segment, page. The segment read goes to (region entry with bits [13:0] cleared) + 8 × address[41:31]. The page read goes to (segment entry with bits [10:0] cleared) + 8 × address[19:12]. Every read address is a multiple of 8.
- R6: The type field is entry bits [3:2]. It must be 2'b11 in a region entry and 2'b10 in a segment entry. If the type field is wrong, or the masked next base is zero, the walk ends on that entry with `rsp_rw`=0 and `rsp_addr`=0, and no further read is issued.
- R7: A page entry that is all zero gives `rsp_rw`=0 and `rsp_addr`=0.
- R8: For a non-zero page entry, `rsp_addr` is the entry with bits [11:0] cleared, which gives a 4 KiB page. `rsp_rw` is 1 unless entry bit 10 (invalid) is set, in which case it is 0. `rsp_msi` is 0.
- R9: At most one read is outstanding. `mem_rd_req` is a one-cycle pulse. `req_ready` is low from the cycle after acceptance until the cycle after the response pulse.
- R10: `rsp_valid` is high for exactly one cycle per request. For a request screened out by R1, R2 or R3, it is high in the cycle after acceptance. For a walk, it is high in the cycle after the acknowledge of the last read.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device DMA address |
| req_origin | input | 64 | Table origin word, flags in [3:0] |
| req_base | input | 64 | Lowest address in the window |
| req_limit | input | 64 | Highest address in the window |
| req_fstate | input | 3 | Function state code |
| req_xlat_en | input | 1 | Translation enabled for the function |
| mem_rd_req | output | 1 | Read request pulse |
| mem_rd_addr | output | 64 | Address of the entry to read |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_rw | output | 1 | Read/write permission granted |
| rsp_msi | output | 1 | Response is routed to the interrupt target |
| rsp_addr | output | 64 | Translated page address |

## Verification
If the walker holds the wrong state, it issues a read to the wrong level's address, or makes an extra read after a bad entry. The next `mem_rd_req` shows this, and the read-address comparison catches it within one read latency. If the screen takes a wrong decision, a read appears where none is allowed, or the response arrives in the wrong cycle. Both are seen in the cycle after acceptance. Errors in masking or field extraction show up in the response fields as soon as the response pulse occurs.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int XW_AW = 64;
  typedef logic [XW_AW-1:0] addr_t;

  typedef enum logic [2:0] {
    FS_RESERVED = 3'd0,
    FS_STANDBY  = 3'd1,
    FS_DISABLED = 3'd2,
    FS_ENABLED  = 3'd3,
    FS_BLOCKED  = 3'd4
  } fstate_e;

  typedef enum logic [1:0] {
    SCR_DENY = 2'd0,
    SCR_MSI  = 2'd1,
    SCR_WALK = 2'd2
  } screen_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RGN  = 2'd1,
    W_SEG  = 2'd2,
    W_PG   = 2'd3
  } walk_st_e;

  // Extract an index field of width w starting at bit lsb.
  function automatic addr_t field(addr_t a, int lsb, int w);
    addr_t m;
    m = (addr_t'(1) << w) - addr_t'(1);
    return (a >> lsb) & m;
  endfunction

  // Address of a table entry: base plus index times eight bytes.
  function automatic addr_t entry_addr(addr_t base, addr_t idx);
    return base + (idx << 3);
  endfunction

  // Clear the low bits of a word below position lsb.
  function automatic addr_t clear_low(addr_t a, int lsb);
    return a & ~((addr_t'(1) << lsb) - addr_t'(1));
  endfunction

endpackage

// File: rtl/xw_screen.sv
module xw_screen
  import xw_pkg::*;
#(
  parameter addr_t MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input  addr_t       addr,
  input  addr_t       base,
  input  addr_t       limit,
  input  logic [2:0]  fstate,
  input  logic        xlat_en,
  output logic        xlat_ok,
  output logic        in_window,
  output screen_e     verdict
);

  logic state_live;

  assign state_live = (fstate == FS_ENABLED) || (fstate == FS_BLOCKED);
  assign xlat_ok    = state_live && xlat_en;
  assign in_window  = (addr >= base) && (addr <= limit);

  always_comb begin
    if (!xlat_ok)              verdict = SCR_DENY;
    else if (addr == MSI_ADDR) verdict = SCR_MSI;
    else if (!in_window)       verdict = SCR_DENY;
    else                       verdict = SCR_WALK;
  end

endmodule

// File: rtl/xw_upper_entry.sv
module xw_upper_entry
  import xw_pkg::*;
#(
  parameter logic [1:0] EXP_TYPE = 2'b11,
  parameter int         TYPE_LSB = 2,
  parameter int         BASE_LSB = 14
) (
  input  addr_t entry,
  output logic  usable,
  output addr_t next_base
);

  assign next_base = clear_low(entry, BASE_LSB);
  assign usable    = (entry[TYPE_LSB +: 2] == EXP_TYPE) && (next_base != '0);

endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
#(
  parameter int         RT_LSB       = 42,
  parameter int         SX_LSB       = 31,
  parameter int         PX_LSB       = 12,
  parameter int         UPIDX_W      = 11,
  parameter int         PXIDX_W      = 8,
  parameter int         TYPE_LSB     = 2,
  parameter logic [1:0] RGN_TYPE     = 2'b11,
  parameter logic [1:0] SEG_TYPE     = 2'b10,
  parameter int         RGN_BASE_LSB = 14,
  parameter int         SEG_BASE_LSB = 11,
  parameter int         PAGE_BITS    = 12,
  parameter int         PTE_INV_BIT  = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  addr_t start_addr,
  input  addr_t start_origin,
  output logic  busy,
  output logic  mem_rd_req,
  output addr_t mem_rd_addr,
  input  logic  mem_rd_ack,
  input  addr_t mem_rd_data,
  output logic  done,
  output logic  done_rw,
  output addr_t done_addr
);

  localparam int N_UPPER = 2;

  walk_st_e st_q;
  logic     rd_req_q;
  addr_t    rd_addr_q;
  addr_t    vaddr_q;

  logic [N_UPPER-1:0] up_ok;
  addr_t              up_base [N_UPPER];

  logic rgn_bad, seg_bad, pg_hit;
  logic pg_nonzero, pg_invalid;

  for (genvar g = 0; g < N_UPPER; g++) begin : g_upper
    localparam logic [1:0] ET = (g == 0) ? RGN_TYPE : SEG_TYPE;
    localparam int         BL = (g == 0) ? RGN_BASE_LSB : SEG_BASE_LSB;
    xw_upper_entry #(
      .EXP_TYPE (ET),
      .TYPE_LSB (TYPE_LSB),
      .BASE_LSB (BL)
    ) u_lvl (
      .entry     (mem_rd_data),
      .usable    (up_ok[g]),
      .next_base (up_base[g])
    );
  end

  assign pg_nonzero = (mem_rd_data != '0);
  assign pg_invalid = mem_rd_data[PTE_INV_BIT];

  // Named walk events
  assign rgn_bad = mem_rd_ack && (st_q == W_RGN) && !up_ok[0];
  assign seg_bad = mem_rd_ack && (st_q == W_SEG) && !up_ok[1];
  assign pg_hit  = mem_rd_ack && (st_q == W_PG);

  assign done      = rgn_bad || seg_bad || pg_hit;
  assign done_rw   = pg_hit && pg_nonzero && !pg_invalid;
  assign done_addr = (pg_hit && pg_nonzero) ? clear_low(mem_rd_data, PAGE_BITS) : '0;

  assign busy        = (st_q != W_IDLE);
  assign mem_rd_req  = rd_req_q;
  assign mem_rd_addr = rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= W_IDLE;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      vaddr_q   <= '0;
    end else begin
      rd_req_q <= 1'b0;
      case (st_q)
        W_IDLE: begin
          if (start) begin
            st_q      <= W_RGN;
            vaddr_q   <= start_addr;
            rd_req_q  <= 1'b1;
            rd_addr_q <= entry_addr(start_origin, field(start_addr, RT_LSB, UPIDX_W));
          end
        end
        W_RGN: begin
          if (mem_rd_ack) begin
            if (up_ok[0]) begin
              st_q      <= W_SEG;
              rd_req_q  <= 1'b1;
              rd_addr_q <= entry_addr(up_base[0], field(vaddr_q, SX_LSB, UPIDX_W));
            end else begin
              st_q <= W_IDLE;
            end
          end
        end
        W_SEG: begin
          if (mem_rd_ack) begin
            if (up_ok[1]) begin
              st_q      <= W_PG;
              rd_req_q  <= 1'b1;
              rd_addr_q <= entry_addr(up_base[1], field(vaddr_q, PX_LSB, PXIDX_W));
            end else begin
              st_q <= W_IDLE;
            end
          end
        end
        W_PG: begin
          if (mem_rd_ack) st_q <= W_IDLE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R9: a read request is a single-cycle pulse
  a_r9_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  // R5: every entry read is eight-byte aligned
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[2:0] == 3'b000));

  // R6: a bad region entry ends the walk with no further read
  a_r6_stop_region: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_bad |=> (st_q == W_IDLE) && !mem_rd_req);

  // R5: a usable region entry leads straight to a segment read
  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_ack && (st_q == W_RGN) && up_ok[0]) |=> (st_q == W_SEG) && mem_rd_req);

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xw_pkg::*;
#(
  parameter addr_t MSI_ADDR     = 64'h0000_0000_FE00_0000,
  parameter addr_t ORG_FLAGS    = 64'h0000_0000_0000_000F,
  parameter int    RT_LSB       = 42,
  parameter int    SX_LSB       = 31,
  parameter int    PX_LSB       = 12,
  parameter int    UPIDX_W      = 11,
  parameter int    PXIDX_W      = 8,
  parameter int    PAGE_BITS    = 12,
  parameter int    PTE_INV_BIT  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  input  logic [63:0] req_origin,
  input  logic [63:0] req_base,
  input  logic [63:0] req_limit,
  input  logic [2:0]  req_fstate,
  input  logic        req_xlat_en,
  output logic        mem_rd_req,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [63:0] mem_rd_data,
  output logic        rsp_valid,
  output logic        rsp_rw,
  output logic        rsp_msi,
  output logic [63:0] rsp_addr
);

  logic    accept;
  logic    xlat_ok, in_window;
  screen_e verdict;
  logic    walk_busy, walk_done, walk_rw;
  addr_t   walk_addr;
  addr_t   table_origin;

  assign req_ready    = !walk_busy && !rsp_valid;
  assign accept       = req_valid && req_ready;
  assign table_origin = req_origin & ~ORG_FLAGS;

  xw_screen #(.MSI_ADDR(MSI_ADDR)) u_screen (
    .addr      (req_addr),
    .base      (req_base),
    .limit     (req_limit),
    .fstate    (req_fstate),
    .xlat_en   (req_xlat_en),
    .xlat_ok   (xlat_ok),
    .in_window (in_window),
    .verdict   (verdict)
  );

  xw_walker #(
    .RT_LSB      (RT_LSB),
    .SX_LSB      (SX_LSB),
    .PX_LSB      (PX_LSB),
    .UPIDX_W     (UPIDX_W),
    .PXIDX_W     (PXIDX_W),
    .PAGE_BITS   (PAGE_BITS),
    .PTE_INV_BIT (PTE_INV_BIT)
  ) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept && (verdict == SCR_WALK)),
    .start_addr   (req_addr),
    .start_origin (table_origin),
    .busy         (walk_busy),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .mem_rd_data  (mem_rd_data),
    .done         (walk_done),
    .done_rw      (walk_rw),
    .done_addr    (walk_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rw    <= 1'b0;
      rsp_msi   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && (verdict != SCR_WALK)) begin
        rsp_valid <= 1'b1;
        rsp_rw    <= (verdict == SCR_MSI);
        rsp_msi   <= (verdict == SCR_MSI);
        rsp_addr  <= (verdict == SCR_MSI) ? req_addr : '0;
      end else if (walk_done) begin
        rsp_valid <= 1'b1;
        rsp_rw    <= walk_rw;
        rsp_msi   <= 1'b0;
        rsp_addr  <= walk_addr;
      end
    end
  end

  // R1: a refused function gets an immediate denial and no read
  a_r1_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlat_ok) |=> rsp_valid && !rsp_rw && !rsp_msi && !mem_rd_req);

  // R2: the interrupt address bypasses the walk
  a_r2_msi: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xlat_ok && (req_addr == MSI_ADDR)) |=> rsp_valid && rsp_msi && rsp_rw && !mem_rd_req);

  // R3: out-of-window addresses are refused without a read
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xlat_ok && (req_addr != MSI_ADDR) && !in_window) |=> rsp_valid && !rsp_rw && !mem_rd_req);

  // R10: the response is a one-cycle pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: no request is taken while a walk is in progress
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);

endmodule

// File: tb/sim_dma_xlate_walker.sv
`timescale 1ns/1ps
module sim_dma_xlate_walker;

  localparam logic [63:0] MSI = 64'h0000_0000_FE00_0000;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_addr, req_origin, req_base, req_limit;
  logic [2:0]  req_fstate;
  logic        req_xlat_en;
  logic        mem_rd_req, mem_rd_ack;
  logic [63:0] mem_rd_addr, mem_rd_data;
  logic        rsp_valid, rsp_rw, rsp_msi;
  logic [63:0] rsp_addr;

  dma_xlate_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_origin(req_origin), .req_base(req_base),
    .req_limit(req_limit), .req_fstate(req_fstate), .req_xlat_en(req_xlat_en),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_rw(rsp_rw),
    .rsp_msi(rsp_msi), .rsp_addr(rsp_addr)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string cur_tag  = "R11";

  logic [63:0] mem [longint unsigned];
  longint unsigned rd_q[$];
  bit              ex_rw_q[$];
  bit              ex_msi_q[$];
  logic [63:0]     ex_addr_q[$];
  string           ex_tag_q[$];

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_get(longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // Behavioural reference: pushes expected reads and the expected response.
  task automatic model(input logic [63:0] a, input logic [63:0] org,
                       input logic [63:0] b, input logic [63:0] l,
                       input logic [2:0] fs, input bit en, input string tag);
    bit rw = 0, msi = 0;
    logic [63:0] ta = 0;
    longint unsigned p, e, nxt;
    if (!((fs == 3 || fs == 4) && en)) begin
    end else if (a == MSI) begin
      rw = 1; msi = 1; ta = a;
    end else if (a < b || a > l) begin
    end else begin
      p = (org - (org % 16)) + ((a / (64'd1 << 42)) % 2048) * 8;
      rd_q.push_back(p);
      e = mem_get(p);
      nxt = e - (e % 16384);
      if (((e / 4) % 4) == 3 && nxt != 0) begin
        p = nxt + ((a / (64'd1 << 31)) % 2048) * 8;
        rd_q.push_back(p);
        e = mem_get(p);
        nxt = e - (e % 2048);
        if (((e / 4) % 4) == 2 && nxt != 0) begin
          p = nxt + ((a / 4096) % 256) * 8;
          rd_q.push_back(p);
          e = mem_get(p);
          if (e != 0) begin
            ta = e - (e % 4096);
            rw = ((e / 1024) % 2) == 0;
          end
        end
      end
    end
    ex_rw_q.push_back(rw);
    ex_msi_q.push_back(msi);
    ex_addr_q.push_back(ta);
    ex_tag_q.push_back(tag);
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] org,
                      input logic [63:0] b, input logic [63:0] l,
                      input logic [2:0] fs, input bit en, input string tag);
    bit screened;
    do @(negedge clk);
    while (!(req_ready && ex_rw_q.size() == 0 && rd_q.size() == 0));
    model(a, org, b, l, fs, en, tag);
    screened = (rd_q.size() == 0);
    cur_tag     = tag;
    req_addr    = a;
    req_origin  = org;
    req_base    = b;
    req_limit   = l;
    req_fstate  = fs;
    req_xlat_en = en;
    req_valid   = 1;
    @(negedge clk);
    req_valid = 0;
    if (screened)
      chk(rsp_valid, "R10", "screened response one cycle after accept", {63'd0, rsp_valid}, 64'd1);
    else
      chk(!req_ready, "R9", "ready low during walk", {63'd0, req_ready}, 64'd0);
  endtask

  // Monitor and memory responder, every falling edge.
  initial begin
    bit prev_rsp = 0, rsp_due = 0, pend = 0;
    int cnt = 0, lat_seed = 0;
    longint unsigned paddr = 0, ea;
    mem_rd_ack = 0;
    mem_rd_data = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          if (ex_rw_q.size() == 0) begin
            chk(0, "R10", "unexpected response", 64'd1, 64'd0);
          end else begin
            string t;
            bit erw, emsi;
            logic [63:0] ead;
            t = ex_tag_q.pop_front();
            erw = ex_rw_q.pop_front();
            emsi = ex_msi_q.pop_front();
            ead = ex_addr_q.pop_front();
            chk(rsp_rw == erw, t, "rsp_rw", {63'd0, rsp_rw}, {63'd0, erw});
            chk(rsp_msi == emsi, t, "rsp_msi", {63'd0, rsp_msi}, {63'd0, emsi});
            chk(rsp_addr == ead, t, "rsp_addr", rsp_addr, ead);
          end
          if (prev_rsp) chk(0, "R10", "response longer than one cycle", 64'd1, 64'd0);
        end
        if (rsp_due) begin
          chk(rsp_valid, "R10", "response after final read", {63'd0, rsp_valid}, 64'd1);
          rsp_due = 0;
        end
        prev_rsp = rsp_valid;
        mem_rd_ack = 0;
        if (pend) begin
          if (cnt == 0) begin
            mem_rd_ack = 1;
            mem_rd_data = mem_get(paddr);
            pend = 0;
            if (rd_q.size() == 0) rsp_due = 1;
          end else begin
            cnt--;
          end
        end
        if (mem_rd_req) begin
          if (pend) chk(0, "R9", "read issued while one outstanding", 64'd1, 64'd0);
          if (rd_q.size() == 0) begin
            chk(0, cur_tag, "unexpected read", mem_rd_addr, 64'd0);
          end else begin
            ea = rd_q.pop_front();
            chk(mem_rd_addr == ea, "R5", "read address", mem_rd_addr, ea);
          end
          pend = 1;
          paddr = mem_rd_addr;
          cnt = lat_seed % 4;
          lat_seed++;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R10", "watchdog expired", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] org, full, a3, pg;
    org  = 64'h10000 | 64'hF;
    full = '1;
    a3   = (64'd1 << 42) | (64'd2 << 31) | (64'd3 << 12) | 64'h5A4;
    pg   = (64'd1 << 42) | (64'd2 << 31);
    // Tables
    mem[64'h10008] = 64'h4000C | 64'h3;
    mem[64'h10010] = 64'h50008;
    mem[64'h40010] = 64'h80808 | 64'h1;
    mem[64'h40018] = 64'h9080C;
    mem[64'h40020] = 64'h8;
    mem[64'h80818] = 64'h12345001;
    mem[64'h80808] = 64'h22225400;

    req_valid = 0; req_addr = 0; req_origin = 0; req_base = 0; req_limit = 0;
    req_fstate = 0; req_xlat_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R11", "ready after reset", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid == 0, "R11", "no response after reset", {63'd0, rsp_valid}, 64'd0);
    chk(mem_rd_req == 0, "R11", "no read after reset", {63'd0, mem_rd_req}, 64'd0);

    send(a3, org, 0, full, 3'd3, 1, "R8");                       // valid page
    send(pg | (64'd1 << 12), org, 0, full, 3'd3, 1, "R8");       // invalid flag
    send(pg | (64'd2 << 12), org, 0, full, 3'd3, 1, "R7");       // zero page entry
    send(64'd2 << 42, org, 0, full, 3'd3, 1, "R6");              // region type wrong
    send((64'd1 << 42) | (64'd3 << 31), org, 0, full, 3'd3, 1, "R6"); // segment type wrong
    send((64'd1 << 42) | (64'd4 << 31), org, 0, full, 3'd3, 1, "R6"); // segment base zero
    send(a3, org, 0, full, 3'd2, 1, "R1");                       // disabled
    send(a3, org, 0, full, 3'd3, 0, "R1");                       // translation off
    send(a3, org, 0, full, 3'd1, 1, "R1");                       // standby
    send(a3, org, 0, full, 3'd0, 1, "R1");                       // reserved
    send(a3, org, 0, full, 3'd4, 1, "R1");                       // blocked translates
    send(MSI, org, 64'd1 << 42, full, 3'd3, 1, "R2");            // bypass outside window
    send(MSI, org, 0, full, 3'd2, 1, "R2");                      // gate checked first
    send((pg | (64'd3 << 12)) - 1, org, pg | (64'd3 << 12), pg | (64'd3 << 12) | 64'hFFF, 3'd3, 1, "R3");
    send(pg | (64'd3 << 12), org, pg | (64'd3 << 12), pg | (64'd3 << 12) | 64'hFFF, 3'd3, 1, "R3");
    send(pg | (64'd3 << 12) | 64'hFFF, org, pg | (64'd3 << 12), pg | (64'd3 << 12) | 64'hFFF, 3'd3, 1, "R3");
    send(pg | (64'd4 << 12), org, pg | (64'd3 << 12), pg | (64'd3 << 12) | 64'hFFF, 3'd3, 1, "R3");
    send((64'h7FF << 42) | (64'd1 << 63), org, 0, full, 3'd3, 1, "R4"); // max region index
    send(a3, org, 0, full, 3'd3, 1, "R8");                       // repeat after denials

    do @(negedge clk);
    while (ex_rw_q.size() != 0 || rd_q.size() != 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule